// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block is the transmit-side DMA engine of an Ethernet MAC. Software builds a ring of descriptors in memory. Each descriptor names a buffer and its byte count. Software hands a descriptor to hardware by setting its ownership bit, then starts the engine by pulsing the poll-demand strobe.

The engine walks the ring from its current slot. For every descriptor it owns, it reads the buffer one 32-bit word at a time over a shared word-wide memory port and streams the bytes out on a valid/ready byte interface, which carries first and last markers. When the final byte of a descriptor has been accepted, the engine writes zero over the descriptor's status word. This hands the descriptor back to software. The engine then moves on to the next slot. When it meets a slot it does not own, it stops and waits for the next poll demand.

Software pads short frames to the 60-byte minimum before queueing them. The engine sends exactly the stored byte count, clamped to the buffer limit.

Top module: `tx_desc_fetch`

## Requirements
- R1: While reset is held, and after it until a poll demand arrives, `tx_valid_o`, `mem_req_o`, `done_irq_o` and `fetch_irq_o` are all low.
- R2: A poll demand that finds the current descriptor's status word with bit 31 (ownership) clear produces exactly one memory read of that word and no stream bytes. The engine then idles.
- R3: For an owned descriptor, the engine emits exactly the byte count held in word 1 bits [10:0]. The bytes are taken from the buffer whose address is word 2 (bits [1:0] ignored). Byte k of each memory word is bits [8k+7:8k], so the order is little-endian.
- R4: `tx_first_o` marks the first byte of a descriptor only when word 1 bit 30 is set. `tx_last_o` marks its final byte only when word 1 bit 29 is set. Neither marker appears on any other byte.
- R5: After the final byte of a descriptor is accepted, the engine writes zero to that descriptor's word 0 and proceeds to the next slot without a new poll demand. If that slot is owned, it is sent too.
- R6: The slot after one whose word 1 bit 31 (end of ring) is set, or after slot RING_DEPTH-1, is slot 0 at the ring base. Descriptors are 16 bytes apart.
- R7: A byte count larger than MAX_BYTES is treated as MAX_BYTES.
- R8: A descriptor with a byte count of zero emits no bytes and is still released.
- R9: When word 1 bit 28 is set, `done_irq_o` pulses for one cycle after the descriptor's release write. When word 1 bit 27 is set and the count is nonzero, `fetch_irq_o` pulses for one cycle after the read of the buffer's final word.
- R10: A poll demand that arrives while the engine is busy is remembered. At the slot where the scan would stop, the ownership word is read once more before the engine idles.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, the byte and its markers stay unchanged.
- R12: `mem_req_o`, `mem_addr_o` and `mem_we_o` stay unchanged from the cycle a request is raised until the cycle `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base_i | input | 32 | Byte address of ring slot 0 |
| kick_i | input | 1 | Poll-demand strobe, one cycle per write |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid this cycle |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_data_o | output | 8 | Stream byte |
| tx_first_o | output | 1 | First byte of a frame |
| tx_last_o | output | 1 | Final byte of a frame |
| tx_ready_i | input | 1 | Downstream accepts the byte |
| done_irq_o | output | 1 | Descriptor-released interrupt pulse |
| fetch_irq_o | output | 1 | Buffer-fully-read interrupt pulse |

## Verification
The hardest case to reach is the remembered poll demand. It must arrive while a frame is streaming, and the next slot must be one that software has not handed over. Its only visible trace is a second read of that slot's ownership word. The bench slows the stream with backpressure and waits for the first byte to leave before pulsing the strobe again. It then counts reads at the next slot's address on the memory port. A sweep of byte counts from 1 to 12 covers every split of the final word, with and without backpressure. Separate runs cover the clamp, zero length, a two-descriptor frame and an early end-of-ring wrap.

// File: rtl/txr_pkg.sv
// Package: descriptor field positions and state encoding shared by the
// transmit ring fetcher. Assumes a 32-bit word memory and 16-byte slots.
package txr_pkg;
    localparam int OWN_BIT       = 31;
    localparam int EOR_BIT       = 31;
    localparam int FIRST_BIT     = 30;
    localparam int LAST_BIT      = 29;
    localparam int IRQ_DONE_BIT  = 28;
    localparam int IRQ_FETCH_BIT = 27;
    localparam int LEN_W         = 11;
    localparam int SLOT_SHIFT    = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_OWN, S_CTL, S_BUF, S_FETCH, S_STREAM, S_RELEASE
    } txr_state_e;

    typedef struct packed {
        logic eor;
        logic irq_done;
        logic irq_fetch;
    } txr_ctl_t;
endpackage

// File: rtl/txr_ring_ptr.sv
// Ring slot pointer: holds the current slot index and forms the slot's
// byte address from the ring base. Assumes DEPTH is a power of two >= 2.
module txr_ring_ptr #(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ring_base_i,
    input  logic        advance_i,
    input  logic        wrap_i,
    output logic [31:0] desc_addr_o
);
    import txr_pkg::*;
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] idx_q;

    // Slot index: step on release, return to 0 on end-of-ring or last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (advance_i)
            idx_q <= (wrap_i || idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end

    assign desc_addr_o = ring_base_i + (32'(idx_q) << SLOT_SHIFT);

    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i && wrap_i |=> !$stable(ring_base_i) || desc_addr_o == ring_base_i)
        else $error("wrap did not return to ring base"); // R6
endmodule

// File: rtl/txr_byte_lane.sv
// Byte lane: holds one fetched memory word and presents its bytes in
// little-endian order on a valid/ready stream with first/last markers.
// Assumes buffers start on a word boundary.
module txr_byte_lane #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             first_i,
    input  logic             last_i,
    input  logic             load_i,
    input  logic [31:0]      word_i,
    input  logic             active_i,
    input  logic             ready_i,
    output logic             tx_valid_o,
    output logic [7:0]       tx_data_o,
    output logic             tx_first_o,
    output logic             tx_last_o,
    output logic             fire_o,
    output logic             word_end_o,
    output logic [LEN_W-1:0] rem_o
);
    logic [31:0]      word_q;
    logic [1:0]       lane_q;
    logic [LEN_W-1:0] rem_q;
    logic             first_q;
    logic             last_q;
    logic [31:0]      shifted;

    // Word holder: capture each buffer word as it returns from memory.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_q <= '0;
        else if (load_i) word_q <= word_i;
    end

    // Byte position, remaining count and marker flags per descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q  <= '0;
            rem_q   <= '0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
        end else if (start_i) begin
            lane_q  <= '0;
            rem_q   <= len_i;
            first_q <= first_i;
            last_q  <= last_i;
        end else if (fire_o) begin
            lane_q  <= lane_q + 1'b1;
            rem_q   <= rem_q - 1'b1;
            first_q <= 1'b0;
        end
    end

    assign shifted    = word_q >> {lane_q, 3'b000};
    assign tx_valid_o = active_i;
    assign tx_data_o  = shifted[7:0];
    assign tx_first_o = active_i && first_q;
    assign tx_last_o  = active_i && last_q && rem_q == LEN_W'(1);
    assign fire_o     = active_i && ready_i;
    assign word_end_o = lane_q == 2'd3;
    assign rem_o      = rem_q;

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !ready_i |=> tx_valid_o && $stable(tx_data_o)
                                   && $stable(tx_first_o) && $stable(tx_last_o))
        else $error("stream changed while stalled"); // R11
endmodule

// File: rtl/tx_desc_fetch.sv
// Transmit descriptor ring fetcher: on a poll demand, scans owned slots,
// reads each buffer word by word, streams its bytes and releases the slot
// by zeroing word 0. Assumes the memory port holds read data valid in the
// ack cycle, and the ring base only changes while the engine is idle.
module tx_desc_fetch #(
    parameter int RING_DEPTH = 64,
    parameter int MAX_BYTES  = 1600
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ring_base_i,
    input  logic        kick_i,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    input  logic        mem_ack_i,
    input  logic [31:0] mem_rdata_i,
    output logic        tx_valid_o,
    output logic [7:0]  tx_data_o,
    output logic        tx_first_o,
    output logic        tx_last_o,
    input  logic        tx_ready_i,
    output logic        done_irq_o,
    output logic        fetch_irq_o
);
    import txr_pkg::*;
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BYTES);

    txr_state_e       state;
    txr_ctl_t         ctl;
    logic             kick_pend;
    logic [31:0]      buf_ptr;
    logic [31:0]      desc_addr;
    logic             advance;
    logic             lane_start, lane_load, lane_active, lane_fire, lane_word_end;
    logic [LEN_W-1:0] lane_rem, len_raw, len_cut;
    logic             owned;
    logic             done_q, fetch_q;

    assign len_raw     = mem_rdata_i[LEN_W-1:0];
    assign len_cut     = (len_raw > MAX_LEN) ? MAX_LEN : len_raw;
    assign owned       = mem_rdata_i[OWN_BIT];
    assign advance     = state == S_RELEASE && mem_ack_i;
    assign lane_start  = state == S_CTL && mem_ack_i;
    assign lane_load   = state == S_FETCH && mem_ack_i;
    assign lane_active = state == S_STREAM;

    // Memory port: one access per memory state, address picked by state.
    always_comb begin
        mem_req_o   = state inside {S_OWN, S_CTL, S_BUF, S_FETCH, S_RELEASE};
        mem_we_o    = state == S_RELEASE;
        mem_wdata_o = '0;
        case (state)
            S_OWN, S_RELEASE: mem_addr_o = desc_addr;
            S_CTL:            mem_addr_o = desc_addr + 32'd4;
            S_BUF:            mem_addr_o = desc_addr + 32'd8;
            S_FETCH:          mem_addr_o = buf_ptr;
            default:          mem_addr_o = '0;
        endcase
    end

    txr_ring_ptr #(.DEPTH(RING_DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .ring_base_i(ring_base_i),
        .advance_i(advance), .wrap_i(ctl.eor), .desc_addr_o(desc_addr)
    );

    txr_byte_lane #(.LEN_W(LEN_W)) u_lane (
        .clk(clk), .rst_n(rst_n),
        .start_i(lane_start), .len_i(len_cut),
        .first_i(mem_rdata_i[FIRST_BIT]), .last_i(mem_rdata_i[LAST_BIT]),
        .load_i(lane_load), .word_i(mem_rdata_i),
        .active_i(lane_active), .ready_i(tx_ready_i),
        .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
        .tx_first_o(tx_first_o), .tx_last_o(tx_last_o),
        .fire_o(lane_fire), .word_end_o(lane_word_end), .rem_o(lane_rem)
    );

    // Sequencer: ownership, control, address, data words, release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else begin
            case (state)
                S_IDLE:    if (kick_i) state <= S_OWN;
                S_OWN:     if (mem_ack_i)
                               state <= owned ? S_CTL
                                      : ((kick_pend || kick_i) ? S_OWN : S_IDLE);
                S_CTL:     if (mem_ack_i) state <= S_BUF;
                S_BUF:     if (mem_ack_i)
                               state <= (lane_rem == '0) ? S_RELEASE : S_FETCH;
                S_FETCH:   if (mem_ack_i) state <= S_STREAM;
                S_STREAM:  if (lane_fire) begin
                               if (lane_rem == LEN_W'(1)) state <= S_RELEASE;
                               else if (lane_word_end)    state <= S_FETCH;
                           end
                S_RELEASE: if (mem_ack_i) state <= S_OWN;
                default:   state <= S_IDLE;
            endcase
        end
    end

    // Remembered poll demand: set while busy, consumed at an ownership check.
    always_ff @(posedge clk) begin
        if (!rst_n)                         kick_pend <= 1'b0;
        else if (state == S_OWN && mem_ack_i) kick_pend <= 1'b0;
        else if (kick_i && state != S_IDLE) kick_pend <= 1'b1;
    end

    // Descriptor control fields and the running buffer word address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl     <= '0;
            buf_ptr <= '0;
        end else begin
            if (lane_start)
                ctl <= '{eor:       mem_rdata_i[EOR_BIT],
                         irq_done:  mem_rdata_i[IRQ_DONE_BIT],
                         irq_fetch: mem_rdata_i[IRQ_FETCH_BIT]};
            if (state == S_BUF && mem_ack_i)
                buf_ptr <= {mem_rdata_i[31:2], 2'b00};
            else if (lane_load)
                buf_ptr <= buf_ptr + 32'd4;
        end
    end

    // Interrupt pulses: release done, and final buffer word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            fetch_q <= 1'b0;
        end else begin
            done_q  <= advance && ctl.irq_done;
            fetch_q <= lane_load && ctl.irq_fetch && lane_rem <= LEN_W'(4);
        end
    end

    assign done_irq_o  = done_q;
    assign fetch_irq_o = fetch_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))
        else $error("memory request dropped or changed before ack"); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq_o |=> !done_irq_o)
        else $error("done interrupt longer than one cycle"); // R9
    AST_LAST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && tx_ready_i && tx_last_o |=> mem_req_o && mem_we_o && !tx_valid_o)
        else $error("no release write after final byte"); // R5
endmodule

// File: tb/tx_desc_fetch_bench.sv
module tx_desc_fetch_bench;
    localparam int DEPTH = 4;
    localparam int MAXB  = 24;
    localparam logic [31:0] RB = 32'h40;

    logic clk = 1'b0, rst_n = 1'b0, kick = 1'b0, ready = 1'b1;
    logic mem_req, mem_we, mem_ack, tx_valid, tx_first, tx_last, done_irq, fetch_irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [7:0]  tx_data;

    tx_desc_fetch #(.RING_DEPTH(DEPTH), .MAX_BYTES(MAXB)) u_tx_desc_fetch (
        .clk(clk), .rst_n(rst_n), .ring_base_i(RB), .kick_i(kick),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_first_o(tx_first),
        .tx_last_o(tx_last), .tx_ready_i(ready),
        .done_irq_o(done_irq), .fetch_irq_o(fetch_irq)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 7 + 3);
    endfunction

    logic [31:0] mem [0:511];
    logic        tb_we = 1'b0;
    logic [8:0]  tb_wa = '0;
    logic [31:0] tb_wd = '0;
    logic [31:0] watch_addr = '0;
    logic [7:0]  cap_d [0:1023];
    logic        cap_f [0:1023];
    logic        cap_l [0:1023];
    int cap_n, done_cnt, fetch_cnt, own_reads, hold_err, req_err;
    logic prev_stall, prev_wait;
    logic [7:0] prev_data;
    logic [31:0] prev_addr;

    // Memory model, stream capture and protocol monitors.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++)
                mem[i] <= (i >= 16 && i < 32) ? 32'h0
                        : {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
            mem_ack <= 1'b0; mem_rdata <= '0;
            cap_n <= 0; done_cnt <= 0; fetch_cnt <= 0; own_reads <= 0;
            hold_err <= 0; req_err <= 0; prev_stall <= 1'b0; prev_wait <= 1'b0;
            prev_data <= '0; prev_addr <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
                else begin
                    mem_rdata <= mem[mem_addr[10:2]];
                    if (mem_addr == watch_addr) own_reads <= own_reads + 1;
                end
            end
            if (tb_we) mem[tb_wa] <= tb_wd;
            if (tx_valid && ready) begin
                cap_d[cap_n] <= tx_data; cap_f[cap_n] <= tx_first;
                cap_l[cap_n] <= tx_last; cap_n <= cap_n + 1;
            end
            if (done_irq)  done_cnt  <= done_cnt + 1;
            if (fetch_irq) fetch_cnt <= fetch_cnt + 1;
            if (prev_stall && !(tx_valid && tx_data == prev_data)) hold_err <= hold_err + 1;
            if (prev_wait && !(mem_req && mem_addr == prev_addr)) req_err <= req_err + 1;
            prev_stall <= tx_valid && !ready; prev_data <= tx_data;
            prev_wait  <= mem_req && !mem_ack; prev_addr <= mem_addr;
        end
    end

    int checks = 0, errors = 0, bp = 0, cyc = 0;
    bit finished = 0;

    // Backpressure pattern, driven away from the active edge.
    initial forever begin
        @(negedge clk);
        cyc++;
        ready = (bp == 0) || (cyc % 3 != 1);
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk); tb_we = 1'b1; tb_wa = addr[10:2]; tb_wd = data;
        @(negedge clk); tb_we = 1'b0;
    endtask

    task automatic pulse_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    int eidx = 0, base_n, exp_n, d0, f0;
    logic [7:0] exp_d [0:1023];
    logic exp_f [0:1023];
    logic exp_l [0:1023];
    logic [31:0] last_w0;

    task automatic begin_frame();
        @(negedge clk);
        base_n = cap_n; exp_n = 0; d0 = done_cnt; f0 = fetch_cnt;
    endtask

    // Write one descriptor at the expected slot and record its expected bytes.
    task automatic post(input bit eor, input bit fs, input bit ls, input bit id,
                        input bit ifc, input int len, input int bufa);
        logic [31:0] a;
        int eff;
        a = RB + 32'(eidx * 16);
        poke(a + 4, {eor, fs, ls, id, ifc, 16'h0, 11'(len)});
        poke(a + 8, 32'(bufa));
        poke(a, 32'h8000_0000);
        eff = (len > MAXB) ? MAXB : len;
        for (int k = 0; k < eff; k++) begin
            exp_d[exp_n] = pat(bufa + k);
            exp_f[exp_n] = fs && (k == 0);
            exp_l[exp_n] = ls && (k == eff - 1);
            exp_n++;
        end
        last_w0 = a;
        eidx = (eor || eidx == DEPTH - 1) ? 0 : eidx + 1;
    endtask

    task automatic wait_release();
        for (int t = 0; t < 3000 && mem[last_w0[10:2]] != 32'h0; t++) @(negedge clk);
        repeat (14) @(negedge clk);
    endtask

    task automatic check_frame(input string rq, input int exp_done, input int exp_fetch);
        int dm = 0, fm = 0;
        chk(cap_n - base_n == exp_n, rq, cap_n - base_n, exp_n);
        for (int k = 0; k < exp_n; k++) begin
            if (cap_d[base_n + k] != exp_d[k]) dm++;
            if (cap_f[base_n + k] != exp_f[k] || cap_l[base_n + k] != exp_l[k]) fm++;
        end
        chk(dm == 0, "R3 byte values", dm, 0);
        chk(fm == 0, "R4 markers", fm, 0);
        chk(mem[last_w0[10:2]] == 32'h0, "R5 release", int'(mem[last_w0[10:2]]), 0);
        chk(done_cnt - d0 == exp_done, "R9 done irq", done_cnt - d0, exp_done);
        chk(fetch_cnt - f0 == exp_fetch, "R9 fetch irq", fetch_cnt - f0, exp_fetch);
    endtask

    task automatic finish_run();
        chk(hold_err == 0, "R11 stall hold", hold_err, 0);
        chk(req_err == 0, "R12 request hold", req_err, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        // R1: quiet outputs in and after reset
        chk(!tx_valid, "R1 valid", tx_valid, 0);
        chk(!mem_req, "R1 req", mem_req, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!tx_valid && !mem_req, "R1 after reset", tx_valid | mem_req, 0);
        chk(!done_irq && !fetch_irq, "R1 irqs", done_irq | fetch_irq, 0);

        // R2: kick with nothing owned
        watch_addr = RB;
        begin_frame();
        r0 = own_reads;
        pulse_kick();
        repeat (20) @(negedge clk);
        chk(own_reads - r0 == 1, "R2 one ownership read", own_reads - r0, 1);
        chk(cap_n == base_n, "R2 no bytes", cap_n - base_n, 0);

        // R3/R4/R9: sweep of counts covering every final-word split
        for (int n = 1; n <= 12; n++) begin
            bp = n % 2;
            begin_frame();
            post(1'b0, 1'b1, 1'b1, n % 3 != 0, n % 2 == 0, n, 32'h100 + n * 32);
            pulse_kick();
            wait_release();
            check_frame("R3 count", (n % 3 != 0) ? 1 : 0, (n % 2 == 0) ? 1 : 0);
        end

        // R7: clamp of an oversize count
        bp = 1;
        begin_frame();
        post(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 30, 32'h400);
        pulse_kick();
        wait_release();
        check_frame("R7 clamp count", 1, 1);

        // R8: zero-length descriptor
        begin_frame();
        post(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 32'h500);
        pulse_kick();
        wait_release();
        check_frame("R8 zero length", 1, 0);

        // R5/R4: two-descriptor frame from one kick
        begin_frame();
        post(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5, 32'h600);
        post(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6, 32'h640);
        pulse_kick();
        wait_release();
        check_frame("R5 chained", 1, 0);

        // R6: early end-of-ring wrap
        if (eidx == DEPTH - 1) begin
            begin_frame();
            post(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 3, 32'h680);
            pulse_kick();
            wait_release();
            check_frame("R6 pre-wrap", 0, 0);
        end
        begin_frame();
        post(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4, 32'h6c0);
        pulse_kick();
        wait_release();
        check_frame("R6 eor slot", 0, 0);
        chk(eidx == 0, "R6 expected slot", eidx, 0);
        begin_frame();
        post(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 7, 32'h700);
        pulse_kick();
        wait_release();
        check_frame("R6 slot after wrap", 1, 0);

        // R10: kick while busy causes a second ownership check
        bp = 1;
        begin_frame();
        post(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8, 32'h740);
        watch_addr = RB + 32'(eidx * 16);
        r0 = own_reads;
        pulse_kick();
        for (int t = 0; t < 500 && cap_n == base_n; t++) @(negedge clk);
        pulse_kick();
        wait_release();
        check_frame("R10 frame", 0, 0);
        chk(own_reads - r0 == 2, "R10 second ownership read", own_reads - r0, 2);

        finish_run();
    end
endmodule